// File: doc/BRIEF.md
# MAC Host Status, Command and Transmit Control

This block is the host-facing control core of a simple Ethernet MAC. It decodes an 8-byte host register window: six write-only bytes hold the station address that the receive filter compares against, one byte pairs the receive status (read) with the receive command (write), and one byte pairs the transmit status (read) with the transmit command (write). Each status register carries an old/new flag in its top bit. A status read returns the value as it stood and marks it old, which withdraws any interrupt it was raising.

On the transmit side the host pushes frame bytes into an internal FIFO over a valid/ready stream and then pulses an end-of-frame strobe. The block drains the FIFO onto an outgoing valid/ready byte stream, appends the 4-byte frame check sequence, and posts a success status. An end-of-frame strobe on an empty FIFO posts underflow instead. The receiver posts its per-frame result through a one-cycle status event. A single registered level interrupt combines new status with the interrupt-enable bits of both command registers.

Stream rules: a byte moves on a cycle where valid and ready are both high. The input side is ready only while the block is accepting and the FIFO has room. The output side holds data and last stable while valid is high and ready is low, and never drops valid before the transfer.

Top module: `mac_host_ctl`

## Requirements
- R1: After reset both status registers read 0x80, both command registers are zero (no interrupt can be enabled), the interrupt is low, the output stream is idle and the transmit input is ready.
- R2: Host address 6 reads receive status and writes receive command; address 7 reads transmit status and writes transmit command; addresses 0 to 5 write station address byte k into station_addr bits 8k+7..8k and read back as 0xFF. host_rdata is combinational from host_addr.
- R3: A read (host_rd) of address 6 or 7 returns the value before the read and sets bit 7 of that status register at the clock edge.
- R4: irq is a register: one cycle after any change it equals (rx bit7 clear and rx_status AND rx_command AND 0x3F nonzero) OR (tx bit7 clear and tx_status AND tx_command AND 0x0F nonzero).
- R5: A transmit command write keeps only bits 3..0; bits 7..6 of the receive command drive rx_match_mode.
- R6: A receive event loads receive status with {2'b00, rx_evt_status} (bit 7 clear) only if bit 7 of the receive status was set before the edge; otherwise the event is dropped and the status is unchanged. An accepted event takes precedence over a same-cycle read.
- R7: tx_in_ready is high exactly while the block is accepting and the FIFO holds fewer than FIFO_DEPTH bytes; accepting clears at the edge that takes tx_eof.
- R8: tx_eof with an empty FIFO sets transmit status to 0x01 two edges later and accepting returns on that same edge.
- R9: tx_eof with data streams the bytes in push order, then the four bytes of the complemented reflected CRC-32 (init 0xFFFFFFFF, polynomial 0xEDB88320) least significant byte first, with tx_out_last on the final byte; the edge that takes that byte sets transmit status to 0x08 and restores accepting. A transmit completion takes precedence over a same-cycle transmit status read.
- R10: While tx_out_valid is high and tx_out_ready low, tx_out_valid, tx_out_data and tx_out_last hold.
- R11: tx_eof while not accepting has no effect, and tx_in_valid while tx_in_ready is low pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on status) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| tx_in_valid | input | 1 | Transmit byte valid |
| tx_in_ready | output | 1 | Transmit ready |
| tx_in_data | input | 8 | Transmit byte |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_out_valid | output | 1 | Outgoing byte valid |
| tx_out_ready | input | 1 | Outgoing byte accepted by the serialiser |
| tx_out_data | output | 8 | Outgoing byte |
| tx_out_last | output | 1 | Final FCS byte marker |
| rx_evt_valid | input | 1 | Receiver posts a frame result |
| rx_evt_status | input | 6 | Frame result bits: 0x01 overflow, 0x02 CRC, 0x04 dribble, 0x08 short, 0x10 end, 0x20 good |
| rx_match_mode | output | 2 | Address filter mode from receive command bits 7..6 |
| station_addr | output | 48 | Station address, byte k at bits 8k+7..8k |
| irq | output | 1 | Level interrupt |

## Verification
A stuck or wrongly set old flag shows as an interrupt that fails to drop one cycle after a status read, or one that never rises after a new event, and as a wrong bit 7 the next time the host reads. A corrupted CRC register or byte index only shows on the four trailing bytes of a frame, so the bench checks a frame with a known check value byte by byte. A lost accepting flag or FIFO count appears within one cycle on tx_in_ready, and under output back-pressure any slip in the held byte is visible on the next stalled cycle.

// File: rtl/mac_host_pkg.sv
package mac_host_pkg;
  localparam int          HOST_AW     = 3;
  localparam int          STA_BYTES   = 6;
  localparam logic [2:0]  ADDR_RXREG  = 3'd6;
  localparam logic [2:0]  ADDR_TXREG  = 3'd7;
  localparam logic [7:0]  STAT_OLD    = 8'h80;
  localparam logic [7:0]  TXS_UNDER   = 8'h01;
  localparam logic [7:0]  TXS_OK      = 8'h08;
  localparam logic [7:0]  RX_EN_MASK  = 8'h3F;
  localparam logic [7:0]  UNMAPPED    = 8'hFF;
  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    TXF_IDLE,
    TXF_START,
    TXF_DATA,
    TXF_FCS
  } txf_state_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int b = 0; b < 8; b++) begin
      if (c[0]) c = (c >> 1) ^ CRC_POLY_R;
      else      c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mh_tx_fifo.sv
module mh_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: the edge logic never pushes into a full FIFO
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R9: the framer never pops an empty FIFO
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/mh_tx_framer.sv
module mh_tx_framer
  import mac_host_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eof_req,
  output logic          accepting,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_count,
  input  logic [7:0]    fifo_dout,
  output logic          fifo_pop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done_ok,
  output logic          done_under
);
  txf_state_e  state_q;
  logic [31:0] crc_q;
  logic [1:0]  idx_q;
  logic [31:0] fcs;
  logic [7:0]  fcs_byte;

  assign fcs      = ~crc_q;
  assign fcs_byte = fcs[{idx_q, 3'b000} +: 8];

  always_comb begin
    out_valid  = (state_q == TXF_DATA) || (state_q == TXF_FCS);
    out_data   = (state_q == TXF_DATA) ? fifo_dout : fcs_byte;
    out_last   = (state_q == TXF_FCS) && (idx_q == 2'd3);
    fifo_pop   = (state_q == TXF_DATA) && out_ready;
    done_under = (state_q == TXF_START) && fifo_empty;
    done_ok    = (state_q == TXF_FCS) && out_ready && (idx_q == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TXF_IDLE;
      crc_q     <= CRC_SEED;
      idx_q     <= '0;
      accepting <= 1'b1;
    end else begin
      case (state_q)
        TXF_IDLE: begin
          if (eof_req && accepting) begin
            accepting <= 1'b0;
            state_q   <= TXF_START;
          end
        end
        TXF_START: begin
          crc_q <= CRC_SEED;
          if (fifo_empty) begin
            accepting <= 1'b1;
            state_q   <= TXF_IDLE;
          end else begin
            state_q <= TXF_DATA;
          end
        end
        TXF_DATA: begin
          if (out_ready) begin
            crc_q <= crc32_step(crc_q, fifo_dout);
            if (fifo_count == CW'(1)) begin
              state_q <= TXF_FCS;
              idx_q   <= '0;
            end
          end
        end
        TXF_FCS: begin
          if (out_ready) begin
            if (idx_q == 2'd3) begin
              state_q   <= TXF_IDLE;
              accepting <= 1'b1;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
        end
        default: state_q <= TXF_IDLE;
      endcase
    end
  end

  // R10: a stalled output holds its byte and marker
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R9: completion and underflow are never reported together
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst) !(done_ok && done_under));
  // R11: no stream activity while the host may still push
  a_r11_quiet_accepting: assert property (@(posedge clk) disable iff (rst) accepting |-> !out_valid);
endmodule

// File: rtl/mh_regfile.sv
module mh_regfile
  import mac_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               rx_evt_valid,
  input  logic [5:0]         rx_evt_code,
  input  logic               tx_done_ok,
  input  logic               tx_done_under,
  output logic               irq,
  output logic [47:0]        station,
  output logic [1:0]         rx_match
);
  logic [7:0] rxs, txs, rxc;
  logic [3:0] txc;
  logic [7:0] sta [STA_BYTES];
  logic       rx_take, rx_hit, tx_hit, irq_d;

  assign rx_take = rx_evt_valid && rxs[7];
  assign rx_hit  = !rxs[7] && |(rxs & rxc & RX_EN_MASK);
  assign tx_hit  = !txs[7] && |(txs[3:0] & txc);
  assign irq_d   = rx_hit || tx_hit;
  assign rx_match = rxc[7:6];

  always_comb begin
    case (addr)
      ADDR_RXREG: rdata = rxs;
      ADDR_TXREG: rdata = txs;
      default:    rdata = UNMAPPED;
    endcase
  end

  for (genvar k = 0; k < STA_BYTES; k++) begin : g_sta
    assign station[8*k +: 8] = sta[k];
    always_ff @(posedge clk) begin
      if (rst)                             sta[k] <= '0;
      else if (wr && addr == HOST_AW'(k))  sta[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxs <= STAT_OLD;
      txs <= STAT_OLD;
      rxc <= '0;
      txc <= '0;
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
      if (wr && addr == ADDR_RXREG) rxc <= wdata;
      if (wr && addr == ADDR_TXREG) txc <= wdata[3:0];
      if (rx_take)                          rxs <= {2'b00, rx_evt_code};
      else if (rd && addr == ADDR_RXREG)    rxs[7] <= 1'b1;
      if (tx_done_ok)                       txs <= TXS_OK;
      else if (tx_done_under)               txs <= TXS_UNDER;
      else if (rd && addr == ADDR_TXREG)    txs[7] <= 1'b1;
    end
  end

  // R3: a receive status read with no accepted event leaves the status old
  a_r3_rx_read_marks_old: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_RXREG && !rx_evt_valid) |=> rdata_rx_old());
  // R4: with both registers old the interrupt is low a cycle later
  a_r4_quiet_when_old: assert property (@(posedge clk) disable iff (rst)
    (rxs[7] && txs[7]) |=> !irq);
  // R6: an event arriving while the status is still new is dropped
  a_r6_drop_when_new: assert property (@(posedge clk) disable iff (rst)
    (rx_evt_valid && !rxs[7] && !rd) |=> $stable(rxs));

  function automatic logic rdata_rx_old();
    return rxs[7];
  endfunction
endmodule

// File: rtl/mac_host_ctl.sv
module mac_host_ctl
  import mac_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               tx_in_valid,
  output logic               tx_in_ready,
  input  logic [7:0]         tx_in_data,
  input  logic               tx_eof,
  output logic               tx_out_valid,
  input  logic               tx_out_ready,
  output logic [7:0]         tx_out_data,
  output logic               tx_out_last,
  input  logic               rx_evt_valid,
  input  logic [5:0]         rx_evt_status,
  output logic [1:0]         rx_match_mode,
  output logic [47:0]        station_addr,
  output logic               irq
);
  logic          accepting, fifo_full, fifo_empty, fifo_pop, push;
  logic [CW-1:0] fifo_count;
  logic [7:0]    fifo_dout;
  logic          done_ok, done_under;

  assign tx_in_ready = accepting && !fifo_full;
  assign push        = tx_in_valid && tx_in_ready;

  mh_tx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(tx_in_data), .pop(fifo_pop),
    .dout(fifo_dout), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  mh_tx_framer #(.CW(CW)) u_framer (
    .clk(clk), .rst(rst), .eof_req(tx_eof), .accepting(accepting),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count), .fifo_dout(fifo_dout),
    .fifo_pop(fifo_pop), .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_data(tx_out_data), .out_last(tx_out_last),
    .done_ok(done_ok), .done_under(done_under)
  );

  mh_regfile u_regs (
    .clk(clk), .rst(rst), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .rdata(host_rdata), .rx_evt_valid(rx_evt_valid),
    .rx_evt_code(rx_evt_status), .tx_done_ok(done_ok), .tx_done_under(done_under),
    .irq(irq), .station(station_addr), .rx_match(rx_match_mode)
  );

  // R7: the edge taking tx_eof closes the input before the next byte
  a_r7_eof_closes: assert property (@(posedge clk) disable iff (rst)
    (tx_eof && accepting) |=> !tx_in_ready);
  // R9: the last marker is only shown on a valid byte
  a_r9_last_valid: assert property (@(posedge clk) disable iff (rst)
    tx_out_last |-> tx_out_valid);
endmodule

// File: tb/mac_host_ctl_test.sv
`timescale 1ns/1ps
module mac_host_ctl_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = 3'd0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       tx_in_valid = 1'b0, tx_in_ready;
  logic [7:0] tx_in_data = 8'd0;
  logic       tx_eof = 1'b0;
  logic       tx_out_valid, tx_out_ready = 1'b0, tx_out_last;
  logic [7:0] tx_out_data;
  logic       rx_evt_valid = 1'b0;
  logic [5:0] rx_evt_status = 6'd0;
  logic [1:0] rx_match_mode;
  logic [47:0] station_addr;
  logic       irq;

  always #4 clk = ~clk;

  mac_host_ctl #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_in_valid(tx_in_valid),
    .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data), .tx_eof(tx_eof),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_out_last(tx_out_last), .rx_evt_valid(rx_evt_valid), .rx_evt_status(rx_evt_status),
    .rx_match_mode(rx_match_mode), .station_addr(station_addr), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int unsigned m_rxs, m_txs, m_rxc, m_txc, m_mode, m_fidx;
  bit          m_irq, m_acc;
  logic [31:0] m_crc;
  logic [7:0]  m_sta [6];
  byte unsigned m_q[$];
  byte unsigned cap[$];

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      bit fb = r[0] ^ d[i];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic check(input string tag, input int unsigned got, input int unsigned exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rxs = 8'h80; m_txs = 8'h80; m_rxc = 0; m_txc = 0; m_irq = 0; m_acc = 1;
    m_mode = 0; m_fidx = 0; m_crc = 32'hFFFFFFFF; m_q.delete();
    for (int k = 0; k < 6; k++) m_sta[k] = 8'h00;
  endtask

  function automatic int unsigned m_rdata();
    if (host_addr == 3'd6) return m_rxs;
    if (host_addr == 3'd7) return m_txs;
    return 8'hFF;
  endfunction

  function automatic int unsigned m_outbyte();
    logic [31:0] f;
    if (m_mode == 2) return m_q[0];
    f = ~m_crc;
    return (f >> (8 * m_fidx)) & 8'hFF;
  endfunction

  task automatic compare_all();
    bit ov = (m_mode == 2) || (m_mode == 3);
    logic [47:0] sx;
    for (int k = 0; k < 6; k++) sx[8*k +: 8] = m_sta[k];
    check("R2/R3 host_rdata", host_rdata, m_rdata());
    check("R4 irq", irq, m_irq);
    check("R7 tx_in_ready", tx_in_ready, m_acc && (m_q.size() < DEPTH));
    check("R9 tx_out_valid", tx_out_valid, ov);
    if (ov) begin
      check("R9 tx_out_data", tx_out_data, m_outbyte());
      check("R9 tx_out_last", tx_out_last, (m_mode == 3) && (m_fidx == 3));
    end
    check("R5 rx_match_mode", rx_match_mode, (m_rxc >> 6) & 3);
    check("R2 station_addr", station_addr[31:0], sx[31:0]);
    check("R2 station_addr hi", station_addr[47:32], sx[47:32]);
    if (tx_out_valid && tx_out_ready) cap.push_back(tx_out_data);
  endtask

  task automatic model_step();
    bit irq_new, rx_old, push;
    irq_new = ((m_rxs & 8'h80) == 0 && (m_rxs & m_rxc & 8'h3F) != 0) ||
              ((m_txs & 8'h80) == 0 && (m_txs & m_txc & 8'h0F) != 0);
    rx_old  = (m_rxs & 8'h80) != 0;
    push    = tx_in_valid && m_acc && (m_q.size() < DEPTH);
    if (host_wr) begin
      if (host_addr == 3'd6) m_rxc = host_wdata;
      else if (host_addr == 3'd7) m_txc = host_wdata & 8'h0F;
      else if (host_addr < 3'd6) m_sta[host_addr] = host_wdata;
    end
    if (rx_evt_valid && rx_old) m_rxs = rx_evt_status;
    else if (host_rd && host_addr == 3'd6) m_rxs = m_rxs | 8'h80;
    if (host_rd && host_addr == 3'd7) m_txs = m_txs | 8'h80;
    case (m_mode)
      0: if (tx_eof && m_acc) begin m_acc = 0; m_mode = 1; end
      1: begin
        m_crc = 32'hFFFFFFFF;
        if (m_q.size() == 0) begin m_txs = 8'h01; m_acc = 1; m_mode = 0; end
        else m_mode = 2;
      end
      2: if (tx_out_ready) begin
        m_crc = ref_crc(m_crc, m_q.pop_front());
        if (m_q.size() == 0) begin m_mode = 3; m_fidx = 0; end
      end
      default: if (tx_out_ready) begin
        if (m_fidx == 3) begin m_txs = 8'h08; m_acc = 1; m_mode = 0; end
        else m_fidx++;
      end
    endcase
    if (push) m_q.push_back(tx_in_data);
    m_irq = irq_new;
  endtask

  task automatic tick();
    #1;
    compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1; tick(); host_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a);
    host_addr = a; host_rd = 1; tick(); host_rd = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    tx_in_valid = 1; tx_in_data = b; tick(); tx_in_valid = 0;
  endtask

  task automatic drain(input bit bp);
    int k = 0;
    while (m_mode != 0 && k < 400) begin
      tx_out_ready = bp ? (k % 3 != 1) : 1'b1;
      tick(); k++;
    end
    tx_out_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string msg = "123456789";
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset values
    host_addr = 3'd6; #1; check("R1 rx status reset", host_rdata, 8'h80);
    host_addr = 3'd7; #1; check("R1 tx status reset", host_rdata, 8'h80);
    check("R1 irq reset", irq, 0);
    check("R1 tx_in_ready reset", tx_in_ready, 1);
    check("R1 tx_out_valid reset", tx_out_valid, 0);
    tick();
    // R2: station address and unmapped reads
    for (int k = 0; k < 6; k++) hwrite(3'(k), 8'h10 + 8'(k * 17));
    check("R2 station byte order", station_addr, 48'h65_54_43_32_21_10);
    for (int k = 0; k < 6; k++) begin host_addr = 3'(k); #1; check("R2 unmapped read", host_rdata, 8'hFF); end
    // R5: rx command and match mode
    hwrite(3'd6, 8'hE0);
    // R6: accepted event, then interrupt
    rx_evt_valid = 1; rx_evt_status = 6'h30; tick(); rx_evt_valid = 0;
    tick();
    check("R4 irq after rx good", irq, 1);
    // R6: second event dropped while status is new
    rx_evt_valid = 1; rx_evt_status = 6'h02; tick(); rx_evt_valid = 0;
    host_addr = 3'd6; #1; check("R6 dropped event", host_rdata, 8'h30);
    // R3: read returns pre-value then marks old
    host_addr = 3'd6; host_rd = 1; #1; check("R3 read value", host_rdata, 8'h30); tick(); host_rd = 0;
    host_addr = 3'd6; #1; check("R3 old flag set", host_rdata, 8'hB0);
    tick();
    check("R4 irq cleared by read", irq, 0);
    // R6: event beats same-cycle read
    host_addr = 3'd6; host_rd = 1; rx_evt_valid = 1; rx_evt_status = 6'h08; tick();
    host_rd = 0; rx_evt_valid = 0;
    host_addr = 3'd6; #1; check("R6 event over read", host_rdata, 8'h08);
    hread(3'd6);
    // R5: tx command masked to low bits (0xF1 keeps only underflow enable)
    hwrite(3'd7, 8'hF1);
    // R8: end-of-frame on empty FIFO
    tx_eof = 1; tick(); tx_eof = 0;
    check("R7 closed after eof", tx_in_ready, 0);
    tick();
    host_addr = 3'd7; #1; check("R8 underflow status", host_rdata, 8'h01);
    tick();
    check("R4 irq on underflow", irq, 1);
    hread(3'd7);
    tick();
    check("R4 irq after tx read", irq, 0);
    // R9 and R10: known check value frame with back-pressure
    cap.delete();
    for (int i = 0; i < msg.len(); i++) push_byte(msg[i]);
    tx_eof = 1; tick(); tx_eof = 0;
    drain(1);
    check("R9 frame length", cap.size(), 13);
    if (cap.size() == 13) begin
      check("R9 fcs byte0", cap[9], 8'h26);
      check("R9 fcs byte1", cap[10], 8'h39);
      check("R9 fcs byte2", cap[11], 8'hF4);
      check("R9 fcs byte3", cap[12], 8'hCB);
    end
    host_addr = 3'd7; #1; check("R9 success status", host_rdata, 8'h08);
    tick();
    check("R5 masked success enable off", irq, 0);
    // R5: enabling success interrupt
    hwrite(3'd7, 8'h08); tick();
    check("R4 irq on success", irq, 1);
    hread(3'd7);
    // R7 and R11: fill FIFO, extra push refused
    cap.delete();
    for (int i = 0; i < DEPTH; i++) push_byte(8'(i * 7 + 3));
    check("R7 full not ready", tx_in_ready, 0);
    tx_in_valid = 1; tx_in_data = 8'hEE; tick(); tx_in_valid = 0;
    tx_eof = 1; tick(); tx_eof = 0;
    // R11: eof and pushes while busy are ignored
    tx_out_ready = 1; tick(); tx_eof = 1; tx_in_valid = 1; tick(); tx_eof = 0; tx_in_valid = 0;
    drain(0);
    check("R11 full frame length", cap.size(), DEPTH + 4);
    if (cap.size() > 0) check("R11 first byte", cap[0], 8'h03);
    tick(); tick();
    check("R11 no second frame", tx_out_valid, 0);
    // R9: completion beats a same-cycle read of tx status
    cap.delete();
    push_byte(8'h5A);
    tx_eof = 1; tick(); tx_eof = 0;
    tx_out_ready = 1;
    while (!(m_mode == 3 && m_fidx == 3)) tick();
    host_addr = 3'd7; host_rd = 1; tick(); host_rd = 0; tx_out_ready = 0;
    host_addr = 3'd7; #1; check("R9 completion over read", host_rdata, 8'h08);
    repeat (3) tick();
    finish_run();
  end
endmodule